// File: doc/BRIEF.md
# Video-Side Nametable Mirroring Remapper

This block sits on the 14-bit address bus of a video processor. That bus has its own 8-bit data path and its own write line. Address bit 13 splits the space into two regions. When bit 13 is low, the access goes to character memory on the cartridge. When bit 13 is high, the access goes to the console's 2 KB nametable memory.

Nametable space is divided into four logical 1 KB pages, chosen by logical bits 11:10. Only two physical 1 KB pages exist, so a one-bit mirroring mode selects how the four logical pages fold onto them.
- In vertical mode, logical bit 11 is dropped.
- In horizontal mode, logical bit 11 takes the place of bit 10.

Addresses 0x3000-0x3FFF select nametables exactly as 0x2000-0x2FFF do. The block contains a synchronous 2 KB nametable memory. Writes are stored on the clock edge, and read data is registered, so it appears one cycle after the address. The mode may change between any two accesses.

Top module: `vnt_remap`

## Requirements
- R1: `chr_sel` is 1 and `nt_sel` is 0 exactly when address bit 13 is 0; otherwise `nt_sel` is 1 and `chr_sel` is 0. Both outputs are combinational.
- R2: With `mir_vert`=1 (vertical mode), `nt_addr` = {addr[10], addr[9:0]}. As a result, 0x2800-0x2FFF alias 0x2000-0x27FF.
- R3: With `mir_vert`=0 (horizontal mode), `nt_addr` = {addr[11], addr[9:0]}. As a result, 0x2400 aliases 0x2000 and 0x2C00 aliases 0x2800.
- R4: Address bit 12 has no effect on nametable accesses, so 0x3000-0x3FFF behave like 0x2000-0x2FFF.
- R5: When `nt_sel`=1 and `wr_en`=1, `wdata` is stored at `nt_addr` on the rising clock edge. When `nt_sel`=1, `rdata` shows the memory word at `nt_addr` from the rising edge after the address is presented.
- R6: A write with address bit 13 low leaves the nametable memory unchanged.
- R7: Memory contents depend only on the physical address. A word written in one mode can be read back in the other mode through any logical address that maps to the same physical word.
- R8: While `rst_n` is low, `rdata` is cleared to 0 at the clock edge.
- R9: When a read and a write hit the same word in the same cycle, `rdata` returns the old contents (read-first).
- R10: After a clock edge at which `nt_sel` was 0, `rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| vaddr | input | 14 | Video-side logical address |
| wr_en | input | 1 | Write strobe, 1 = write |
| wdata | input | 8 | Write data |
| mir_vert | input | 1 | Mirroring mode: 0 = horizontal, 1 = vertical |
| chr_sel | output | 1 | Access targets character memory |
| nt_sel | output | 1 | Access targets nametable memory |
| nt_addr | output | 11 | Physical nametable address |
| rdata | output | 8 | Registered nametable read data |

## Verification
The same low address offset is tried in all four logical pages under both modes.
- Under vertical mode, the results must agree for pages 0/2 and for pages 1/3.
- Under horizontal mode, the results must agree for pages 0/1 and for pages 2/3.
- This pattern is the only one that tells the two fold choices apart.

Addresses with bit 12 set, and character-space addresses that share low bits with a written nametable word, separate a correct decode from one that looks at too few or too many bits. A write followed by a read of the same word in the other mode shows that storage is keyed by physical address. Writing and reading the same word in one cycle fixes the read-first ordering.

// File: rtl/vnt_pkg.sv
package vnt_pkg;
   typedef enum logic {
      MIR_HORZ = 1'b0,
      MIR_VERT = 1'b1
   } mir_mode_e;

   typedef enum logic {
      RD_OLD = 1'b0,
      RD_NEW = 1'b1
   } rw_order_e;
endpackage

// File: rtl/vnt_decode.sv
module vnt_decode #(
   parameter int ADDR_W = 14
) (
   input  logic sel_bit,
   output logic chr_sel,
   output logic nt_sel
);
   // The region is chosen by the top address bit only; the remaining bits are
   // passed on to the fold stage untouched.
   always_comb begin
      nt_sel  = sel_bit;
      chr_sel = ~sel_bit;
   end
endmodule

// File: rtl/vnt_fold.sv
module vnt_fold
   import vnt_pkg::*;
#(
   parameter int PAGE_W = 10,
   localparam int IN_W  = PAGE_W + 2,
   localparam int OUT_W = PAGE_W + 1
) (
   input  logic [IN_W-1:0]  laddr,
   input  mir_mode_e        mode,
   output logic [OUT_W-1:0] paddr
);
   logic page_bit;

   always_comb begin
      unique case (mode)
         MIR_VERT: page_bit = laddr[PAGE_W];
         MIR_HORZ: page_bit = laddr[PAGE_W+1];
         default:  page_bit = laddr[PAGE_W];
      endcase
      paddr = {page_bit, laddr[PAGE_W-1:0]};
   end
endmodule

// File: rtl/vnt_ram.sv
module vnt_ram
   import vnt_pkg::*;
#(
   parameter int        AW    = 11,
   parameter int        DW    = 8,
   parameter rw_order_e ORDER = RD_OLD,
   localparam int       DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wd,
   output logic [DW-1:0] rd
);
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_next;

   always_ff @(posedge clk) begin
      if (en && we) mem[addr] <= wd;
   end

   generate
      if (ORDER == RD_NEW) begin : g_wr_thru
         always_comb rd_next = we ? wd : mem[addr];
      end else begin : g_rd_first
         always_comb rd_next = mem[addr];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)  rd <= '0;
      else if (en) rd <= rd_next;
   end
endmodule

// File: rtl/vnt_remap.sv
module vnt_remap
   import vnt_pkg::*;
#(
   parameter int        ADDR_W = 14,
   parameter int        DATA_W = 8,
   parameter int        PAGE_W = 10,
   parameter rw_order_e ORDER  = RD_OLD,
   localparam int       PHYS_W = PAGE_W + 1,
   localparam int       FOLD_W = PAGE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mir_vert,
   output logic              chr_sel,
   output logic              nt_sel,
   output logic [PHYS_W-1:0] nt_addr,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (ADDR_W < FOLD_W + 1) begin : g_bad_width
         $error("vnt_remap: ADDR_W must leave a select bit above the page bits");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("vnt_remap: DATA_W must be positive");
      end
   endgenerate

   mir_mode_e mode;
   assign mode = mir_mode_e'(mir_vert);

   vnt_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel_bit (vaddr[ADDR_W-1]),
      .chr_sel (chr_sel),
      .nt_sel  (nt_sel)
   );

   vnt_fold #(.PAGE_W(PAGE_W)) u_fold (
      .laddr (vaddr[FOLD_W-1:0]),
      .mode  (mode),
      .paddr (nt_addr)
   );

   vnt_ram #(.AW(PHYS_W), .DW(DATA_W), .ORDER(ORDER)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (nt_sel),
      .we    (wr_en),
      .addr  (nt_addr),
      .wd    (wdata),
      .rd    (rdata)
   );
endmodule

// File: rtl/vnt_remap_chk.sv
module vnt_remap_chk #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 10,
   localparam int PHYS_W = PAGE_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] vaddr,
   input logic              mir_vert,
   input logic              chr_sel,
   input logic              nt_sel,
   input logic [PHYS_W-1:0] nt_addr,
   input logic [DATA_W-1:0] rdata
);
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({chr_sel, nt_sel}) == 1 && nt_sel == vaddr[ADDR_W-1]); // R1

   AST_VERT_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (nt_sel && mir_vert) |-> nt_addr == {vaddr[PAGE_W], vaddr[PAGE_W-1:0]}); // R2

   AST_HORZ_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (nt_sel && !mir_vert) |-> nt_addr == {vaddr[PAGE_W+1], vaddr[PAGE_W-1:0]}); // R3

   AST_UPPER_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (nt_sel && vaddr[ADDR_W-2]) |-> nt_addr[PAGE_W-1:0] == vaddr[PAGE_W-1:0]); // R4

   AST_CHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !nt_sel |=> $stable(rdata)); // R10
endmodule

bind vnt_remap vnt_remap_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .mir_vert(mir_vert),
   .chr_sel(chr_sel), .nt_sel(nt_sel), .nt_addr(nt_addr), .rdata(rdata)
);

// File: tb/vnt_remap_tb.sv
module vnt_remap_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [13:0] vaddr;
   logic        wr_en;
   logic [7:0]  wdata;
   logic        mir_vert;
   logic        chr_sel, nt_sel;
   logic [10:0] nt_addr;
   logic [7:0]  rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   vnt_remap u_dut (
      .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .wr_en(wr_en), .wdata(wdata),
      .mir_vert(mir_vert), .chr_sel(chr_sel), .nt_sel(nt_sel),
      .nt_addr(nt_addr), .rdata(rdata)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [13:0] a, input logic [7:0] d, input logic m);
      @(negedge clk);
      vaddr = a; wdata = d; wr_en = 1'b1; mir_vert = m;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [13:0] a, input logic m, output logic [7:0] d);
      @(negedge clk);
      vaddr = a; wr_en = 1'b0; mir_vert = m;
      @(negedge clk);
      d = rdata;
   endtask

   task automatic map(input logic [13:0] a, input logic m, input int exp, input string req);
      @(negedge clk);
      vaddr = a; wr_en = 1'b0; mir_vert = m;
      #1;
      chk(req, nt_addr, exp);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; vaddr = 14'h0000; wr_en = 1'b0; wdata = 8'h00; mir_vert = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 reset rdata", rdata, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_select();
      @(negedge clk); vaddr = 14'h1FFF; #1;
      chk("R1 chr_sel at 1FFF", chr_sel, 1);
      chk("R1 nt_sel at 1FFF", nt_sel, 0);
      @(negedge clk); vaddr = 14'h2000; #1;
      chk("R1 chr_sel at 2000", chr_sel, 0);
      chk("R1 nt_sel at 2000", nt_sel, 1);
   endtask

   task automatic t_fold_map();
      map(14'h2405, 1'b1, 11'h405, "R2 vert 2405");
      map(14'h2C05, 1'b1, 11'h405, "R2 vert 2C05");
      map(14'h2805, 1'b1, 11'h005, "R2 vert 2805");
      map(14'h2405, 1'b0, 11'h005, "R3 horz 2405");
      map(14'h2805, 1'b0, 11'h405, "R3 horz 2805");
      map(14'h2C05, 1'b0, 11'h405, "R3 horz 2C05");
      map(14'h3805, 1'b1, 11'h005, "R4 vert 3805");
      map(14'h3405, 1'b0, 11'h005, "R4 horz 3405");
   endtask

   task automatic t_vertical();
      logic [7:0] d;
      wr(14'h2010, 8'hA1, 1'b1);
      wr(14'h2410, 8'hB2, 1'b1);
      rd(14'h2810, 1'b1, d); chk("R2 vert 2810 reads page0", d, 8'hA1);
      rd(14'h2C10, 1'b1, d); chk("R2 vert 2C10 reads page1", d, 8'hB2);
      // R5 latency: new address, value unchanged before the edge
      @(negedge clk); vaddr = 14'h2010; #1;
      chk("R5 rdata before edge", rdata, 8'hB2);
      @(negedge clk);
      chk("R5 rdata after edge", rdata, 8'hA1);
   endtask

   task automatic t_horizontal();
      logic [7:0] d;
      wr(14'h2020, 8'hC3, 1'b0);
      wr(14'h2820, 8'hD4, 1'b0);
      rd(14'h2420, 1'b0, d); chk("R3 horz 2420 reads page0", d, 8'hC3);
      rd(14'h2C20, 1'b0, d); chk("R3 horz 2C20 reads page1", d, 8'hD4);
   endtask

   task automatic t_upper();
      logic [7:0] d;
      rd(14'h3020, 1'b0, d); chk("R4 horz 3020", d, 8'hC3);
      wr(14'h3430, 8'hE5, 1'b1);
      rd(14'h2430, 1'b1, d); chk("R4 write 3430 read 2430", d, 8'hE5);
   endtask

   task automatic t_chr_write();
      logic [7:0] d;
      wr(14'h0010, 8'hFF, 1'b1);
      wr(14'h1810, 8'hEE, 1'b1);
      rd(14'h2010, 1'b1, d); chk("R6 chr write ignored", d, 8'hA1);
   endtask

   task automatic t_mode_switch();
      logic [7:0] d;
      wr(14'h2440, 8'h66, 1'b1);
      rd(14'h2840, 1'b0, d); chk("R7 vert write horz read", d, 8'h66);
      wr(14'h2C60, 8'h77, 1'b0);
      rd(14'h2460, 1'b1, d); chk("R7 horz write vert read", d, 8'h77);
   endtask

   task automatic t_read_first();
      logic [7:0] d;
      wr(14'h2050, 8'h11, 1'b1);
      @(negedge clk);
      vaddr = 14'h2050; wdata = 8'h22; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R9 read-first old data", rdata, 8'h11);
      rd(14'h2050, 1'b1, d); chk("R9 new data stored", d, 8'h22);
   endtask

   task automatic t_hold();
      @(negedge clk); vaddr = 14'h0050; wr_en = 1'b0;
      @(negedge clk); chk("R10 hold after chr access", rdata, 8'h22);
      @(negedge clk); chk("R10 hold second cycle", rdata, 8'h22);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_select();
      t_fold_map();
      t_vertical();
      t_horizontal();
      t_upper();
      t_chr_write();
      t_mode_switch();
      t_read_first();
      t_hold();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end
endmodule